// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block paces a small two-stage processor front end from a single oscillator clock. It divides the clock by four into a repeating set of four non-overlapping phase strobes, Q1 to Q4, so that one instruction cycle spans four oscillator periods and later logic can act on the phase it needs. Program words and data use separate buses, so the next word can be fetched while the current one executes.

A program counter drives the fetch address to a program memory port of 14-bit words for the whole instruction cycle. At the Q4 edge the word on the port goes into the instruction register, and the counter moves on, so the new address shows from Q1 of the next cycle. That register is the execute slot for the next four phases, while the word after it is being fetched. The execute stage may request a branch with a target address. The request is taken only at Q4 of a cycle that holds a real instruction. When it is taken, the counter loads the target, the prefetched word is dropped, and one empty execute cycle follows. Decoding, the ALU and the memories belong to the surrounding design.

Top module: `quad_phase_sequencer`

## Requirements
- R1: `q_phase` is always one-hot. Bit 0 is Q1 and bit 3 is Q4. The set bit moves to the next phase on each oscillator clock and returns from Q4 to Q1, so one instruction cycle lasts four clocks.
- R2: While reset is asserted, and for the first clock after it is released, `q_phase` reads Q1 (4'b0001), `fetch_addr` is 0, `exec_word` holds the NOP encoding (all zeros by default) and `exec_valid` is 0.
- R3: `fetch_addr` changes only at the clock edge that ends Q4. Without a taken branch it advances by one, so the address fetched in one cycle is one more than the address fetched in the cycle before.
- R4: `fetch_latch` is high exactly during Q4. The word present on `prog_word` at the end of Q4 appears on `exec_word`, with `exec_valid` high, from the following Q1 through Q4. Outside the Q4 edge, `exec_word` and `exec_valid` do not change.
- R5: If `branch_req` is high at the end of Q4 while `exec_valid` is high, the branch is taken. The next cycle fetches from `branch_target`, and its execute slot is a bubble: `exec_word` holds NOP and `exec_valid` is 0. The cycle after that executes the target word.
- R6: `branch_req` has no effect when it is high during Q1 to Q3, or during a bubble cycle. In those cases the fetch sequence continues by one.
- R7: The program counter is 13 bits wide, and the address after 0x1FFF is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; four periods make one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_phase | output | 4 | One-hot phase strobes, bit 0 = Q1 through bit 3 = Q4 |
| fetch_addr | output | 13 | Program memory address for the word being fetched |
| fetch_latch | output | 1 | High during Q4, when the fetched word is captured |
| prog_word | input | 14 | Word read from program memory at `fetch_addr` |
| exec_word | output | 14 | Instruction register, the word in the execute slot |
| exec_valid | output | 1 | Execute slot holds a real instruction (0 for a bubble) |
| branch_req | input | 1 | Branch request from the execute stage |
| branch_target | input | 13 | Branch destination address |

## Verification
Assertions check on every cycle that the phase strobe stays one-hot and rotates. They also check that the counter and the instruction register are stable outside the Q4 edge, that the counter steps by one or lands on the requested target, that a taken branch always leaves exactly one bubble, and that a bubble never lasts longer than one cycle. Only the bench's scenarios can show that a request during Q1 to Q3 or during a bubble is ignored at the ports, that fetched words reach the execute slot in program order after straight-line runs and after jumps, that the counter wraps past the top of the address space, and that a reset in the middle of a cycle restarts at Q1. A behavioural model checks each of these against every output on every clock.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

   // Number of phases in one instruction cycle.
   localparam int unsigned QS_PHASES = 4;

   typedef enum logic [1:0] {
      QS_Q1 = 2'd0,
      QS_Q2 = 2'd1,
      QS_Q3 = 2'd2,
      QS_Q4 = 2'd3
   } qs_phase_e;

endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
   import qseq_pkg::*;
#(
   parameter bit ONEHOT_RING = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [QS_PHASES-1:0] strobe
);

   generate
      if (ONEHOT_RING) begin : g_ring
         // Rotating one-hot ring: no decoder behind the strobe outputs.
         logic [QS_PHASES-1:0] ring_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ring_q <= QS_PHASES'(1);
            else        ring_q <= {ring_q[QS_PHASES-2:0], ring_q[QS_PHASES-1]};
         end
         assign strobe = ring_q;
      end else begin : g_count
         // Two-bit counter with a decoder: fewer flops, one gate level more.
         qs_phase_e cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= QS_Q1;
            else        cnt_q <= qs_phase_e'(cnt_q + 2'd1);
         end
         always_comb begin
            strobe = '0;
            strobe[cnt_q] = 1'b1;
         end
      end
   endgenerate

   // R1: exactly one phase is active at any time.
   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(strobe) == 1);

   // R1: each phase hands over to the next one on the following clock.
   for (genvar i = 0; i < QS_PHASES; i++) begin : g_rot_chk
      p_rotate_r1: assert property (@(posedge clk) disable iff (!rst_n)
         strobe[i] |=> strobe[(i + 1) % QS_PHASES]);
   end

endmodule

// File: rtl/qseq_pc_unit.sv
module qseq_pc_unit #(
   parameter int unsigned PC_W = 13
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,      // Q4 edge: cycle boundary
   input  logic            take,      // branch taken at this boundary
   input  logic [PC_W-1:0] target,
   output logic [PC_W-1:0] pc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pc <= '0;
      else if (take) pc <= target;
      else if (step) pc <= pc + PC_W'(1);
   end

   // R3: the address holds for the whole instruction cycle.
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(pc));

   // R3 / R7: a cycle without a branch advances by one, modulo 2**PC_W.
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !take) |=> pc == $past(pc) + PC_W'(1));

   // R5: a taken branch puts the target on the fetch address.
   p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> pc == $past(target));

endmodule

// File: rtl/qseq_ir_stage.sv
module qseq_ir_stage #(
   parameter int unsigned        WORD_W   = 14,
   parameter logic [WORD_W-1:0]  NOP_WORD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch,      // Q4 strobe
   input  logic              br_req,
   input  logic [WORD_W-1:0] prog_word,
   output logic              take,
   output logic [WORD_W-1:0] exec_word,
   output logic              exec_valid
);

   // A request counts only at Q4 and only from a real instruction.
   assign take = latch & br_req & exec_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exec_word  <= NOP_WORD;
         exec_valid <= 1'b0;
      end else if (latch) begin
         if (take) begin
            exec_word  <= NOP_WORD;     // drop the prefetched word
            exec_valid <= 1'b0;
         end else begin
            exec_word  <= prog_word;
            exec_valid <= 1'b1;
         end
      end
   end

   // R4: the execute slot changes only at the Q4 edge.
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> ($stable(exec_word) && $stable(exec_valid)));

   // R5: a taken branch leaves a NOP bubble in the execute slot.
   p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!exec_valid && exec_word == NOP_WORD));

   // R6: a bubble lasts one cycle; a request during it cannot extend it.
   p_bubble_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && !exec_valid) |=> exec_valid);

endmodule

// File: rtl/quad_phase_sequencer.sv
module quad_phase_sequencer
   import qseq_pkg::*;
#(
   parameter int unsigned       PC_W        = 13,
   parameter int unsigned       WORD_W      = 14,
   parameter logic [WORD_W-1:0] NOP_WORD    = '0,
   parameter bit                ONEHOT_RING = 1'b1
) (
   input  logic              clk_osc,
   input  logic              rst_n,
   output logic [3:0]        q_phase,
   output logic [PC_W-1:0]   fetch_addr,
   output logic              fetch_latch,
   input  logic [WORD_W-1:0] prog_word,
   output logic [WORD_W-1:0] exec_word,
   output logic              exec_valid,
   input  logic              branch_req,
   input  logic [PC_W-1:0]   branch_target
);

   localparam int unsigned Q4_IDX = QS_PHASES - 1;

   generate
      if (PC_W < 2 || PC_W > 16) begin : g_bad_pc_w
         $error("quad_phase_sequencer: PC_W must lie in 2..16");
      end
      if (WORD_W < 8 || WORD_W > 32) begin : g_bad_word_w
         $error("quad_phase_sequencer: WORD_W must lie in 8..32");
      end
   endgenerate

   logic [QS_PHASES-1:0] strobe;
   logic                 take;

   qseq_phase_gen #(
      .ONEHOT_RING (ONEHOT_RING)
   ) u_phase (
      .clk    (clk_osc),
      .rst_n  (rst_n),
      .strobe (strobe)
   );

   qseq_ir_stage #(
      .WORD_W   (WORD_W),
      .NOP_WORD (NOP_WORD)
   ) u_ir (
      .clk        (clk_osc),
      .rst_n      (rst_n),
      .latch      (strobe[Q4_IDX]),
      .br_req     (branch_req),
      .prog_word  (prog_word),
      .take       (take),
      .exec_word  (exec_word),
      .exec_valid (exec_valid)
   );

   qseq_pc_unit #(
      .PC_W (PC_W)
   ) u_pc (
      .clk    (clk_osc),
      .rst_n  (rst_n),
      .step   (strobe[Q4_IDX]),
      .take   (take),
      .target (branch_target),
      .pc     (fetch_addr)
   );

   assign q_phase     = strobe;
   assign fetch_latch = strobe[Q4_IDX];

endmodule

// File: tb/quad_phase_sequencer_tb.sv
module quad_phase_sequencer_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk_osc = 1'b0;
   logic        rst_n;
   logic [3:0]  q_phase;
   logic [12:0] fetch_addr;
   logic        fetch_latch;
   logic [13:0] prog_word;
   logic [13:0] exec_word;
   logic        exec_valid;
   logic        branch_req;
   logic [12:0] branch_target;

   int    vectors     = 0;
   int    miscompares = 0;
   string ctx         = "R2 reset";
   bit    done        = 1'b0;

   always #(CLK_PERIOD / 2) clk_osc = ~clk_osc;

   quad_phase_sequencer u_dut (
      .clk_osc       (clk_osc),
      .rst_n         (rst_n),
      .q_phase       (q_phase),
      .fetch_addr    (fetch_addr),
      .fetch_latch   (fetch_latch),
      .prog_word     (prog_word),
      .exec_word     (exec_word),
      .exec_valid    (exec_valid),
      .branch_req    (branch_req),
      .branch_target (branch_target)
   );

   // Program ROM model: a scrambled function of the address.
   function automatic logic [13:0] rom_f(input logic [12:0] a);
      logic [13:0] t;
      t = 14'(int'(a) * 37 + 11);
      return t ^ 14'h0A5C;
   endfunction

   assign prog_word = rom_f(fetch_addr);

   // Behavioural reference: phase number, counter, execute slot.
   int          m_phase;
   logic [12:0] m_pc;
   logic [13:0] m_ir;
   logic        m_valid;

   always @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n) begin
         m_phase <= 0;
         m_pc    <= '0;
         m_ir    <= '0;
         m_valid <= 1'b0;
      end else begin
         if (m_phase == 3) begin
            if (branch_req && m_valid) begin
               m_pc    <= branch_target;
               m_ir    <= '0;
               m_valid <= 1'b0;
            end else begin
               m_ir    <= rom_f(m_pc);
               m_valid <= 1'b1;
               m_pc    <= m_pc + 13'd1;
            end
         end
         m_phase <= (m_phase + 1) % 4;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every output on the falling edge, away from the active edge.
   always @(negedge clk_osc) begin
      if (!done) begin
         chk({"R1 q_phase ", ctx}, 32'(q_phase), 32'(4'b0001 << m_phase));
         chk({"R4 fetch_latch ", ctx}, 32'(fetch_latch), 32'(m_phase == 3));
         chk({"R3 fetch_addr ", ctx}, 32'(fetch_addr), 32'(m_pc));
         chk({"R4 exec_word ", ctx}, 32'(exec_word), 32'(m_ir));
         chk({"R4 exec_valid ", ctx}, 32'(exec_valid), 32'(m_valid));
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk_osc);
         #2;
      end
   endtask

   // Raise a request for one Q4 period; optionally wait for a real instruction.
   task automatic req_at_q4(input logic [12:0] tgt, input bit need_valid);
      tick(1);
      while (!(m_phase == 3 && (m_valid || !need_valid))) tick(1);
      branch_req    = 1'b1;
      branch_target = tgt;
      tick(1);
      branch_req    = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   logic [15:0] lfsr = 16'hACE1;

   initial begin
      rst_n         = 1'b0;
      branch_req    = 1'b0;
      branch_target = '0;
      ctx = "R2 reset";
      tick(3);
      rst_n = 1'b1;
      tick(1);

      ctx = "R3 R4 straight-line";
      tick(40);

      ctx = "R5 taken branch";
      req_at_q4(13'h0100, 1'b1);
      tick(16);

      ctx = "R6 request in bubble";
      req_at_q4(13'h0040, 1'b1);
      req_at_q4(13'h0777, 1'b0);   // lands on the bubble's Q4
      tick(16);

      ctx = "R6 request outside Q4";
      tick(1);
      while (m_phase != 0) tick(1);
      branch_req    = 1'b1;
      branch_target = 13'h1234;
      tick(3);                     // high through Q1..Q3 only
      branch_req    = 1'b0;
      tick(12);

      ctx = "R7 counter wrap";
      req_at_q4(13'h1FFE, 1'b1);
      tick(24);

      ctx = "R5 R6 random requests";
      for (int i = 0; i < 3000; i++) begin
         lfsr          = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         branch_req    = (lfsr[2:0] == 3'd0);
         branch_target = lfsr[15:3];
         tick(1);
      end
      branch_req = 1'b0;

      ctx = "R2 reset mid-cycle";
      tick(2);
      rst_n = 1'b0;
      tick(5);
      rst_n = 1'b1;
      ctx = "R2 restart";
      tick(20);

      finish_run();
   end

endmodule